// File: doc/BRIEF.md
# Programmable Sequential Pattern Matcher

The block watches a vector of bus signals every clock and raises a one-cycle event when a programmed pattern has been seen. The pattern can be a single masked compare, or an ordered series of compares. Each comparator holds a runtime value and a runtime mask. A small sequencer, also programmed at runtime, decides which comparator hit each state waits for and where a hit leads. A per-state time limit sends the sequencer back to its start state when the next expected hit does not arrive in time.

All settings arrive through a serial chain that works like a scan data register. Bits shift into a shadow copy while the monitored bus and the matcher keep running. An update strobe then copies the shadow into the active settings in one clock. The matcher only observes the bus, so it cannot disturb it, and several instances can watch different interfaces at the same time. The bus width, the number of comparators, the number of states and the timer width are parameters.

Top module: `spm_matcher`

## Requirements
- R1: After reset the event output and the serial output are 0. The shadow and active settings are all zero, so every mask is zero and the enable bit is clear.
- R2: Comparator c hits when ((bus_i ^ value_c) & mask_c) == 0. A mask bit of 0 makes that bus bit a don't-care.
- R3: While shift_en_i is 1, each clock shifts shift_in_i into the top bit of the shadow, and the shadow moves one place toward bit 0, so bits are loaded LSB-first. shift_out_o always shows shadow bit 0. Shifted bits have no effect on matching until update_i is 1 at a clock edge, which copies the whole shadow into the active settings.
- R4: Setting layout, from bit 0 upward: bit 0 is enable. Next, for each comparator in turn, come W value bits and then W mask bits. Last, for each waiting state s = 0 .. NSTATE-2 in turn, come a comparator select (CSW bits), a next state (SW bits) and a time limit (TW bits). With the defaults (W=8, 2 comparators, 4 states, TW=4) the chain is 54 bits long, and each state field is 7 bits wide and starts at bit 33 + 7*s.
- R5: In waiting state s, a hit on the selected comparator moves the sequencer to the programmed next state. Every hit restarts the state timer. State 0 is the start state.
- R6: A hit whose next state is the final state NSTATE-1 makes event_o 1 for exactly the one cycle after the clock edge that sampled the hit. The sequencer returns to state 0 at that same edge.
- R7: In a waiting state other than 0 with a nonzero time limit T, the hit is accepted if it is sampled within T cycles after entering the state. With no hit by cycle T, the sequencer returns to state 0. A limit of 0 means no time limit.
- R8: While the active enable bit is 0, event_o stays 0 and the sequencer is held in state 0.
- R9: An update strobe puts the sequencer back in state 0, so a partly matched sequence does not carry over into new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_i | input | W | Monitored signal vector |
| shift_en_i | input | 1 | Shift one setting bit per clock |
| shift_in_i | input | 1 | Serial setting data, LSB first |
| update_i | input | 1 | Copy the shadow settings into the active settings |
| shift_out_o | output | 1 | Shadow bit 0, for chaining |
| event_o | output | 1 | One-cycle pattern-detected pulse |

## Verification
The bench drives the bus on falling edges. The event for a bus value sampled at a rising edge is registered at that edge, so it is checked at the very next falling edge, one cycle after the value was applied. shift_out_o changes at each shifting edge, so it is compared before every shift against the bit loaded one configuration earlier. An update counts from the edge where the strobe is sampled: the first bus value applied after that edge is already judged by the new settings. Sweeps over all 256 bus values for several value and mask pairs, and directed sequences placed exactly at and just past the time limit, are predicted from the requirement formulas.

// File: rtl/spm_pkg.sv
package spm_pkg;

  // Total length of the serial settings chain.
  function automatic int unsigned cfg_bits(input int unsigned w, input int unsigned ncmp,
                                           input int unsigned nstate, input int unsigned csw,
                                           input int unsigned sw, input int unsigned tw);
    return 1 + ncmp * 2 * w + (nstate - 1) * (csw + sw + tw);
  endfunction

endpackage

// File: rtl/spm_cfg_chain.sv
module spm_cfg_chain #(
  parameter int unsigned LEN = 54
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en_i,
  input  logic           shift_in_i,
  input  logic           update_i,
  output logic           shift_out_o,
  output logic [LEN-1:0] active_o
);

  logic [LEN-1:0] shadow_q;
  logic [LEN-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shift_en_i) shadow_q <= {shift_in_i, shadow_q[LEN-1:1]};
      if (update_i)   active_q <= shadow_q;
    end
  end

  assign shift_out_o = shadow_q[0];
  assign active_o    = active_q;

  // Shadow only moves while shifting.
  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !shift_en_i |=> $stable(shadow_q));
  // Active settings only change on an update strobe.
  p_active_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !update_i |=> $stable(active_q));

endmodule

// File: rtl/spm_cmp.sv
module spm_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] bus_i,
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);

  assign hit_o = ~|((bus_i ^ value_i) & mask_i);

endmodule

// File: rtl/spm_seq.sv
module spm_seq #(
  parameter int unsigned NCMP   = 2,
  parameter int unsigned NSTATE = 4,
  parameter int unsigned CSW    = 1,
  parameter int unsigned SW     = 2,
  parameter int unsigned TW     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en_i,
  input  logic                       restart_i,
  input  logic [NCMP-1:0]            hits_i,
  input  logic [(NSTATE-1)*CSW-1:0]  sel_i,
  input  logic [(NSTATE-1)*SW-1:0]   nxt_i,
  input  logic [(NSTATE-1)*TW-1:0]   tmo_i,
  output logic                       event_o
);

  localparam logic [SW-1:0] LAST = SW'(NSTATE - 1);

  logic [SW-1:0]  state_q;
  logic [TW-1:0]  cnt_q;
  logic           ev_q;
  logic [CSW-1:0] cur_sel;
  logic [SW-1:0]  cur_nxt;
  logic [TW-1:0]  cur_tmo;
  logic           cur_hit;
  logic           go_final;
  logic           timed_out;

  always_comb begin
    cur_sel   = sel_i[int'(state_q) * CSW +: CSW];
    cur_nxt   = nxt_i[int'(state_q) * SW +: SW];
    cur_tmo   = tmo_i[int'(state_q) * TW +: TW];
    cur_hit   = hits_i[cur_sel];
    go_final  = cur_hit && (cur_nxt == LAST);
    timed_out = !cur_hit && (state_q != '0) && (cur_tmo != '0) &&
                (cnt_q == cur_tmo - TW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i || !en_i) begin
      state_q <= '0;
      cnt_q   <= '0;
      ev_q    <= 1'b0;
    end else begin
      ev_q <= go_final;
      if (cur_hit) begin
        state_q <= go_final ? '0 : cur_nxt;
        cnt_q   <= '0;
      end else if (timed_out) begin
        state_q <= '0;
        cnt_q   <= '0;
      end else if (state_q != '0 && cnt_q != '1) begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end

  assign event_o = ev_q;

  p_state_range_r5: assert property (@(posedge clk) disable iff (rst)
    state_q != LAST);
  p_event_home_r6: assert property (@(posedge clk) disable iff (rst)
    event_o |-> state_q == '0);
  p_tmo_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q != '0 && cur_tmo != '0) |-> cnt_q < cur_tmo);
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (state_q == '0 && !event_o));
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (state_q == '0 && !event_o));

endmodule

// File: rtl/spm_matcher.sv
module spm_matcher #(
  parameter int unsigned W      = 8,
  parameter int unsigned NCMP   = 2,
  parameter int unsigned NSTATE = 4,
  parameter int unsigned TW     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_i,
  input  logic         shift_en_i,
  input  logic         shift_in_i,
  input  logic         update_i,
  output logic         shift_out_o,
  output logic         event_o
);

  localparam int unsigned CSW   = (NCMP > 1) ? $clog2(NCMP) : 1;
  localparam int unsigned SW    = $clog2(NSTATE);
  localparam int unsigned NWAIT = NSTATE - 1;
  localparam int unsigned SF    = CSW + SW + TW;
  localparam int unsigned SBASE = 1 + NCMP * 2 * W;
  localparam int unsigned LEN   = spm_pkg::cfg_bits(W, NCMP, NSTATE, CSW, SW, TW);

  logic [LEN-1:0]       act;
  logic [NCMP-1:0]      hits;
  logic [NWAIT*CSW-1:0] sel_f;
  logic [NWAIT*SW-1:0]  nxt_f;
  logic [NWAIT*TW-1:0]  tmo_f;

  spm_cfg_chain #(.LEN(LEN)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .shift_en_i (shift_en_i),
    .shift_in_i (shift_in_i),
    .update_i   (update_i),
    .shift_out_o(shift_out_o),
    .active_o   (act)
  );

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    spm_cmp #(.W(W)) u_cmp (
      .bus_i  (bus_i),
      .value_i(act[1 + c*2*W +: W]),
      .mask_i (act[1 + c*2*W + W +: W]),
      .hit_o  (hits[c])
    );
  end

  for (genvar s = 0; s < NWAIT; s++) begin : g_state
    assign sel_f[s*CSW +: CSW] = act[SBASE + s*SF +: CSW];
    assign nxt_f[s*SW +: SW]   = act[SBASE + s*SF + CSW +: SW];
    assign tmo_f[s*TW +: TW]   = act[SBASE + s*SF + CSW + SW +: TW];
  end

  spm_seq #(.NCMP(NCMP), .NSTATE(NSTATE), .CSW(CSW), .SW(SW), .TW(TW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .en_i     (act[0]),
    .restart_i(update_i),
    .hits_i   (hits),
    .sel_i    (sel_f),
    .nxt_i    (nxt_f),
    .tmo_i    (tmo_f),
    .event_o  (event_o)
  );

endmodule

// File: tb/spm_matcher_tb.sv
module spm_matcher_tb;

  localparam int L = 54;
  localparam logic [7:0] PA = 8'h3C;
  localparam logic [7:0] PB = 8'hA5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus = '0;
  logic       sh_en = 1'b0;
  logic       sh_in = 1'b0;
  logic       upd = 1'b0;
  logic       sh_out;
  logic       ev;

  int checks = 0;
  int errors = 0;
  logic [L-1:0] last_cfg = '0;

  always #4 clk = ~clk;

  spm_matcher u_dut (
    .clk(clk), .rst(rst), .bus_i(bus), .shift_en_i(sh_en), .shift_in_i(sh_in),
    .update_i(upd), .shift_out_o(sh_out), .event_o(ev)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // Settings built from the layout of R4.
  function automatic logic [L-1:0] mk(input logic en, input logic [7:0] v0, input logic [7:0] m0,
                                      input logic [7:0] v1, input logic [7:0] m1,
                                      input int s0, input int n0, input int t0,
                                      input int s1, input int n1, input int t1,
                                      input int s2, input int n2, input int t2);
    logic [L-1:0] c;
    c = '0;
    c[0] = en;
    c[8:1] = v0;  c[16:9] = m0;  c[24:17] = v1;  c[32:25] = m1;
    c[33 +: 7] = {4'(t0), 2'(n0), 1'(s0)};
    c[40 +: 7] = {4'(t1), 2'(n1), 1'(s1)};
    c[47 +: 7] = {4'(t2), 2'(n2), 1'(s2)};
    return c;
  endfunction

  task automatic strobe();
    upd = 1'b1;
    @(posedge clk); @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic load(input logic [L-1:0] v, input bit do_upd);
    for (int i = 0; i < L; i++) begin
      chk(sh_out, last_cfg[i], "R3 serial out");
      sh_en = 1'b1; sh_in = v[i];
      @(posedge clk); @(negedge clk);
    end
    sh_en = 1'b0;
    last_cfg = v;
    if (do_upd) strobe();
  endtask

  task automatic step(input logic [7:0] b, input logic exp, input string tag);
    bus = b;
    @(posedge clk); @(negedge clk);
    chk(ev, exp, tag);
  endtask

  task automatic sweep(input int sel, input logic [7:0] v, input logic [7:0] m, input string tag);
    if (sel == 0) load(mk(1, v, m, 8'h00, 8'hFF, 0, 3, 0, 0, 0, 0, 0, 0, 0), 1);
    else          load(mk(1, 8'h00, 8'hFF, v, m, 1, 3, 0, 0, 0, 0, 0, 0, 0), 1);
    for (int b = 0; b < 256; b++)
      step(8'(b), (((8'(b) ^ v) & m) == 8'h00), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [L-1:0] seq_cfg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state; the first load also reads back an all-zero shadow.
    chk(ev, 1'b0, "R1 event after reset");
    chk(sh_out, 1'b0, "R1 serial out after reset");
    step(8'h00, 1'b0, "R1 disabled after reset");

    // R2: exhaustive sweeps on both comparators.
    sweep(0, 8'h5A, 8'hF0, "R2 cmp0 upper nibble");
    sweep(0, PA, 8'hFF, "R2 cmp0 full mask");
    sweep(1, 8'h0F, 8'h81, "R2 cmp1 sparse mask");
    sweep(0, 8'hC3, 8'h00, "R2 zero mask");

    // R8: enable clear, all-hit masks, no event.
    load(mk(0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 3, 0, 0, 0, 0, 0, 0, 0), 1);
    for (int i = 0; i < 4; i++) step(8'(i * 37), 1'b0, "R8 disabled");

    // R3: shifting without update has no effect.
    load(mk(1, PA, 8'hFF, 8'h00, 8'h00, 0, 3, 0, 0, 0, 0, 0, 0, 0), 1);
    load(mk(1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 3, 0, 0, 0, 0, 0, 0, 0), 0);
    step(8'h00, 1'b0, "R3 shadow not applied");
    step(PA, 1'b1, "R3 old settings active");
    strobe();
    step(8'h00, 1'b1, "R3 new settings after update");

    // R5/R6: A then B then A, with time limits of 3 cycles.
    seq_cfg = mk(1, PA, 8'hFF, PB, 8'hFF, 0, 1, 0, 1, 2, 3, 0, 3, 3);
    load(seq_cfg, 1);
    step(PA, 1'b0, "R5 first stage");
    step(PB, 1'b0, "R5 second stage");
    step(PA, 1'b1, "R6 sequence done");
    step(PA, 1'b0, "R6 single pulse");
    step(PB, 1'b0, "R5 middle stage");
    step(8'h00, 1'b0, "R5 idle");
    step(PA, 1'b1, "R6 sequence done again");
    step(PB, 1'b0, "R5 out of order from start");
    step(PA, 1'b0, "R5 restart first stage");

    // R7: hit at the limit is accepted.
    step(8'h00, 1'b0, "R7 wait");
    step(PB, 1'b0, "R7 hit at cycle 2");
    step(8'h00, 1'b0, "R7 wait");
    step(8'h00, 1'b0, "R7 wait");
    step(PA, 1'b1, "R7 hit at limit");
    // R7: one cycle late is rejected.
    step(PA, 1'b0, "R7 enter stage 1");
    step(8'h00, 1'b0, "R7 wait");
    step(8'h00, 1'b0, "R7 wait");
    step(8'h00, 1'b0, "R7 limit reached");
    step(PB, 1'b0, "R7 late hit ignored");
    step(PA, 1'b0, "R7 restarted at stage 0");
    step(PB, 1'b0, "R7 stage 1");
    step(PA, 1'b1, "R7 completes after restart");

    // R7: a zero limit never expires.
    load(mk(1, PA, 8'hFF, PB, 8'hFF, 0, 1, 0, 1, 2, 0, 0, 3, 0), 1);
    step(PA, 1'b0, "R7 no limit enter");
    for (int i = 0; i < 20; i++) step(8'h00, 1'b0, "R7 no limit wait");
    step(PB, 1'b0, "R7 no limit stage 2");
    step(PA, 1'b1, "R7 no limit completes");

    // R9: an update abandons a partial match.
    step(PA, 1'b0, "R9 partial match");
    step(PB, 1'b0, "R9 partial match");
    strobe();
    step(PA, 1'b0, "R9 restarted after update");
    step(PB, 1'b0, "R9 stage 2 again");
    step(PA, 1'b1, "R9 full sequence fires");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule